// File: doc/BRIEF.md
# Next Program Counter Selector

This block holds the program counter of a simple 32-bit processor with word addressing, and works out the address of the next instruction. It builds two candidate addresses from the current counter. The first is the incremented counter. The second is a branch target: the incremented counter plus a sign-extended 16-bit word offset. It also forms a jump target by placing the 26-bit target field of the instruction under the top bits of the incremented counter.

The next address comes from three 2:1 stages, each with its own select bit and a fixed polarity. The first stage picks between the register operand (jump-register) and the incremented counter. The second stage can replace that result with the branch target. The third stage can replace everything with the jump target. The counter register takes the chosen address only on a cycle where the load strobe is high. The control sequencer raises that strobe once per instruction, in the write-back step. The incremented counter is also an output, so that jump-and-link can write it to the link register.

The branch select is decided outside this block. Control raises it for branch-if-equal when the ALU zero flag is 1, and for branch-if-not-equal when the flag is 0. A synchronous reset loads a start address set by a parameter.

Top module: `next_pc_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `pc_q` becomes `START_ADDR` (default 32'h0000_0100). This holds even when `pc_load` is also high.
- R2: When `pc_load` is low and `rst` is low at a rising edge, `pc_q` keeps its value.
- R3: When `pc_load` is high and `rst` is low at a rising edge, `pc_q` takes the value that `next_pc` had just before that edge.
- R4: `pc_plus1` equals `pc_q + 1` modulo 2^32, so 32'hFFFF_FFFF is followed by 0.
- R5: With `sel_branch`=0 and `sel_jump_n`=1, `next_pc` is `reg_target` when `sel_reg_n`=0 and `pc_plus1` when `sel_reg_n`=1.
- R6: With `sel_branch`=1 and `sel_jump_n`=1, `next_pc` is `pc_plus1 + sign_extend(imm)` whatever the value of `sel_reg_n`.
- R7: With `sel_jump_n`=0, `next_pc` is {`pc_plus1`[31:26], `jump_field`[25:0]} whatever the values of the other two selects. The top six bits come from the incremented counter, not from `pc_q`.
- R8: A negative offset (bit 15 of `imm` set) moves the target backward and wraps modulo 2^32. For example, with `pc_q`=0 and `imm`=16'hFFFF the target is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pc_load | input | 1 | Update strobe for the counter (write-back step) |
| sel_reg_n | input | 1 | Stage 1 select: 0 = register operand, 1 = incremented counter |
| sel_branch | input | 1 | Stage 2 select: 1 = branch target, 0 = pass stage 1 |
| sel_jump_n | input | 1 | Stage 3 select: 0 = jump target, 1 = pass stage 2 |
| reg_target | input | 32 | Register operand for jump-register |
| imm | input | 16 | Signed branch offset in words |
| jump_field | input | 26 | Target field of a jump instruction |
| pc_q | output | 32 | Current program counter |
| pc_plus1 | output | 32 | Incremented counter, also the link value |
| next_pc | output | 32 | Address selected for the next load |

## Verification
The hardest cases to reach are the ones that depend on the counter value itself. These are the wrap of the increment at the top of the address space, a backward branch that crosses zero, and a jump made from the last word before a 2^26 boundary. In that last case the top bits of the incremented counter differ from those of the current counter. Reaching these needs the counter at a chosen value, and the ports offer no direct write. The bench gets there by loading the counter through the jump-register path with the wanted value, and then applies the corner-case stimulus. It also applies all three selects together, to show that the later stages have precedence.

// File: rtl/npc_pkg.sv
`timescale 1ns/1ps
package npc_pkg;
   // Select bundle for the three-stage cascade
   typedef struct packed {
      logic reg_n;    // stage 1: 0 picks register operand
      logic branch;   // stage 2: 1 picks branch target
      logic jump_n;   // stage 3: 0 picks jump target
   } npc_sel_t;

   localparam int unsigned NPC_ADDR_W_DEF = 32;
   localparam int unsigned NPC_IMM_W_DEF  = 16;
   localparam int unsigned NPC_JUMP_W_DEF = 26;
endpackage

// File: rtl/npc_target_calc.sv
`timescale 1ns/1ps
module npc_target_calc #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned IMM_W  = 16,
   parameter int unsigned JUMP_W = 26
) (
   input  logic [ADDR_W-1:0] pc_q,
   input  logic [IMM_W-1:0]  imm,
   input  logic [JUMP_W-1:0] jump_field,
   output logic [ADDR_W-1:0] pc_plus1,
   output logic [ADDR_W-1:0] branch_tgt,
   output logic [ADDR_W-1:0] jump_tgt
);
   localparam int unsigned UPPER_W = ADDR_W - JUMP_W;
   localparam int unsigned EXT_W   = ADDR_W - IMM_W;

   logic [ADDR_W-1:0] imm_ext;

   generate
      if (IMM_W > ADDR_W) begin : g_bad_imm
         $error("npc_target_calc: IMM_W exceeds ADDR_W");
      end
      if (JUMP_W >= ADDR_W) begin : g_bad_jump
         $error("npc_target_calc: JUMP_W must be below ADDR_W");
      end
      if (IMM_W < ADDR_W) begin : g_sext
         assign imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
      end else begin : g_full
         assign imm_ext = imm[ADDR_W-1:0];
      end
   endgenerate

   assign pc_plus1   = pc_q + ADDR_W'(1);
   assign branch_tgt = pc_plus1 + imm_ext;
   assign jump_tgt   = {pc_plus1[ADDR_W-1 -: UPPER_W], jump_field};

   // R4: the increment steps by one and wraps at the top
   always_comb begin
      a_inc_r4: assert ((pc_plus1 - pc_q) == ADDR_W'(1) || $isunknown(pc_q));
   end
endmodule

// File: rtl/npc_mux_stage.sv
`timescale 1ns/1ps
module npc_mux_stage #(
   parameter int unsigned W      = 32,
   parameter bit          ALT_ON = 1'b1
) (
   input  logic         sel,
   input  logic [W-1:0] base,
   input  logic [W-1:0] alt,
   output logic [W-1:0] y
);
   generate
      if (W == 0) begin : g_bad_w
         $error("npc_mux_stage: W must be nonzero");
      end
   endgenerate

   always_comb begin
      y = (sel == ALT_ON) ? alt : base;
   end
endmodule

// File: rtl/npc_select_chain.sv
`timescale 1ns/1ps
module npc_select_chain
   import npc_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned JUMP_W = 26
) (
   input  logic              clk,
   input  logic              rst,
   input  npc_sel_t          sel,
   input  logic [ADDR_W-1:0] reg_target,
   input  logic [ADDR_W-1:0] pc_plus1,
   input  logic [ADDR_W-1:0] branch_tgt,
   input  logic [ADDR_W-1:0] jump_tgt,
   input  logic [JUMP_W-1:0] jump_field,
   output logic [ADDR_W-1:0] next_pc
);
   logic [ADDR_W-1:0] s1_out;
   logic [ADDR_W-1:0] s2_out;

   // Stage 1: register operand when select is 0
   npc_mux_stage #(.W(ADDR_W), .ALT_ON(1'b0)) u_stage_reg (
      .sel(sel.reg_n), .base(pc_plus1), .alt(reg_target), .y(s1_out));
   // Stage 2: branch target when select is 1
   npc_mux_stage #(.W(ADDR_W), .ALT_ON(1'b1)) u_stage_branch (
      .sel(sel.branch), .base(s1_out), .alt(branch_tgt), .y(s2_out));
   // Stage 3: jump target when select is 0
   npc_mux_stage #(.W(ADDR_W), .ALT_ON(1'b0)) u_stage_jump (
      .sel(sel.jump_n), .base(s2_out), .alt(jump_tgt), .y(next_pc));

   p_reg_path_r5: assert property (@(posedge clk) disable iff (rst)
      (!sel.reg_n && !sel.branch && sel.jump_n) |-> next_pc == reg_target);
   p_inc_path_r5: assert property (@(posedge clk) disable iff (rst)
      (sel.reg_n && !sel.branch && sel.jump_n) |-> next_pc == pc_plus1);
   p_branch_wins_r6: assert property (@(posedge clk) disable iff (rst)
      (sel.branch && sel.jump_n) |-> next_pc == branch_tgt);
   p_jump_low_r7: assert property (@(posedge clk) disable iff (rst)
      !sel.jump_n |-> next_pc[JUMP_W-1:0] == jump_field);
   p_jump_high_r7: assert property (@(posedge clk) disable iff (rst)
      !sel.jump_n |-> next_pc[ADDR_W-1:JUMP_W] == pc_plus1[ADDR_W-1:JUMP_W]);
endmodule

// File: rtl/npc_pc_reg.sv
`timescale 1ns/1ps
module npc_pc_reg #(
   parameter int unsigned       ADDR_W     = 32,
   parameter logic [ADDR_W-1:0] START_ADDR = '0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [ADDR_W-1:0] d,
   output logic [ADDR_W-1:0] q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         q <= START_ADDR;
      end else if (load) begin
         q <= d;
      end
   end

   p_reset_start_r1: assert property (@(posedge clk)
      rst |=> q == START_ADDR);
   p_hold_r2: assert property (@(posedge clk) disable iff (rst)
      !load |=> $stable(q));
   p_load_r3: assert property (@(posedge clk) disable iff (rst)
      load |=> q == $past(d));
endmodule

// File: rtl/next_pc_unit.sv
`timescale 1ns/1ps
module next_pc_unit
   import npc_pkg::*;
#(
   parameter int unsigned       ADDR_W     = NPC_ADDR_W_DEF,
   parameter int unsigned       IMM_W      = NPC_IMM_W_DEF,
   parameter int unsigned       JUMP_W     = NPC_JUMP_W_DEF,
   parameter logic [ADDR_W-1:0] START_ADDR = ADDR_W'(32'h0000_0100)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              pc_load,
   input  logic              sel_reg_n,
   input  logic              sel_branch,
   input  logic              sel_jump_n,
   input  logic [ADDR_W-1:0] reg_target,
   input  logic [IMM_W-1:0]  imm,
   input  logic [JUMP_W-1:0] jump_field,
   output logic [ADDR_W-1:0] pc_q,
   output logic [ADDR_W-1:0] pc_plus1,
   output logic [ADDR_W-1:0] next_pc
);
   npc_sel_t          sel;
   logic [ADDR_W-1:0] branch_tgt;
   logic [ADDR_W-1:0] jump_tgt;

   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("next_pc_unit: ADDR_W too small");
      end
   endgenerate

   assign sel = '{reg_n: sel_reg_n, branch: sel_branch, jump_n: sel_jump_n};

   npc_target_calc #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .JUMP_W(JUMP_W)) u_calc (
      .pc_q(pc_q), .imm(imm), .jump_field(jump_field),
      .pc_plus1(pc_plus1), .branch_tgt(branch_tgt), .jump_tgt(jump_tgt));

   npc_select_chain #(.ADDR_W(ADDR_W), .JUMP_W(JUMP_W)) u_chain (
      .clk(clk), .rst(rst), .sel(sel), .reg_target(reg_target),
      .pc_plus1(pc_plus1), .branch_tgt(branch_tgt), .jump_tgt(jump_tgt),
      .jump_field(jump_field), .next_pc(next_pc));

   npc_pc_reg #(.ADDR_W(ADDR_W), .START_ADDR(START_ADDR)) u_pc (
      .clk(clk), .rst(rst), .load(pc_load), .d(next_pc), .q(pc_q));
endmodule

// File: tb/test_next_pc_unit.sv
`timescale 1ns/1ps
module test_next_pc_unit;
   localparam logic [31:0] START = 32'h0000_0100;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        pc_load = 1'b0;
   logic        sel_reg_n = 1'b1, sel_branch = 1'b0, sel_jump_n = 1'b1;
   logic [31:0] reg_target = '0;
   logic [15:0] imm = '0;
   logic [25:0] jump_field = '0;
   logic [31:0] pc_q, pc_plus1, next_pc;

   int   n_run = 0;
   int   n_fail = 0;
   bit   done = 1'b0;
   logic [31:0] exp_pc;

   always #2.5 clk = ~clk;

   next_pc_unit i_next_pc_unit (
      .clk(clk), .rst(rst), .pc_load(pc_load),
      .sel_reg_n(sel_reg_n), .sel_branch(sel_branch), .sel_jump_n(sel_jump_n),
      .reg_target(reg_target), .imm(imm), .jump_field(jump_field),
      .pc_q(pc_q), .pc_plus1(pc_plus1), .next_pc(next_pc));

   // Independent model of the requirements (R5, R6, R7, R8)
   function automatic logic [31:0] model(input logic [31:0] pc, input logic [2:0] s,
                                         input logic [31:0] r, input logic [15:0] i,
                                         input logic [25:0] j);
      logic [31:0] p1, a;
      p1 = pc + 32'd1;
      a  = s[2] ? p1 : r;
      if (s[1]) a = p1 + {{16{i[15]}}, i};
      if (!s[0]) a = {p1[31:26], j};
      return a;
   endfunction

   function automatic string tag_of(input logic ld, input logic [2:0] s);
      if (!ld)  return "R2";
      if (!s[0]) return "R7";
      if (s[1]) return "R6";
      return "R5";
   endfunction

   task automatic check(input string tag, input string what,
                        input logic [31:0] got, input logic [31:0] expv);
      n_run++;
      if (got !== expv) begin
         n_fail++;
         $display("FAIL %s %s got %h expected %h", tag, what, got, expv);
      end
   endtask

   // apply one instruction step; s = {sel_reg_n, sel_branch, sel_jump_n}
   task automatic step(input logic ld, input logic [2:0] s, input logic [31:0] r,
                       input logic [15:0] i, input logic [25:0] j, input string tag);
      logic [31:0] nx;
      @(negedge clk);
      pc_load = ld; {sel_reg_n, sel_branch, sel_jump_n} = s;
      reg_target = r; imm = i; jump_field = j;
      #1;
      nx = model(exp_pc, s, r, i, j);
      check(tag, "next_pc", next_pc, nx);
      check("R4", "pc_plus1", pc_plus1, exp_pc + 32'd1);
      @(posedge clk); #1;
      if (ld) exp_pc = nx;
      check(ld ? "R3" : "R2", "pc_q", pc_q, exp_pc);
   endtask

   // {load, sel[2:0], reg_target, imm, jump_field}
   localparam int NV = 8;
   localparam logic [77:0] VEC [0:NV-1] = '{
      {1'b1, 3'b101, 32'h1234_5678, 16'h0000, 26'h000_0000}, // R5 increment
      {1'b1, 3'b001, 32'h0000_4000, 16'h0000, 26'h000_0000}, // R5 jump-register
      {1'b1, 3'b111, 32'hDEAD_BEEF, 16'h0010, 26'h000_0000}, // R6 forward branch
      {1'b1, 3'b111, 32'h0000_0000, 16'hFFF0, 26'h000_0000}, // R8 backward branch
      {1'b1, 3'b100, 32'h0000_0000, 16'h0000, 26'h0AB_CDEF}, // R7 jump
      {1'b0, 3'b001, 32'h5555_0000, 16'h0000, 26'h000_0000}, // R2 hold
      {1'b1, 3'b011, 32'h7777_0000, 16'h0004, 26'h000_0000}, // R6 over register
      {1'b1, 3'b010, 32'h7777_0000, 16'h0004, 26'h123_4567}  // R7 over branch
   };

   initial begin
      #100000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      // R1: reset wins even with load and a jump selected
      pc_load = 1'b1; sel_jump_n = 1'b0; jump_field = 26'h3FF_FFFF;
      repeat (3) @(posedge clk);
      #1;
      exp_pc = START;
      check("R1", "pc_q after reset", pc_q, START);
      @(negedge clk); rst = 1'b0; pc_load = 1'b0; sel_jump_n = 1'b1;

      for (int k = 0; k < NV; k++) begin
         logic [77:0] v;
         v = VEC[k];
         step(v[77], v[76:74], v[73:42], v[41:26], v[25:0], tag_of(v[77], v[76:74]));
      end

      // R4: increment wraps at the top of the address space
      step(1'b1, 3'b001, 32'hFFFF_FFFF, 16'h0, 26'h0, "R5");
      #1 check("R4", "pc_plus1 wrap", pc_plus1, 32'h0000_0000);
      // R8: backward branch across zero (pc 0, offset -1 -> 0)
      step(1'b1, 3'b001, 32'h0000_0000, 16'h0, 26'h0, "R5");
      step(1'b1, 3'b111, 32'h0, 16'hFFFF, 26'h0, "R8");
      check("R8", "pc_q after wrap branch", pc_q, 32'h0000_0000);
      // R7: upper bits come from the incremented counter
      step(1'b1, 3'b001, 32'h03FF_FFFF, 16'h0, 26'h0, "R5");
      step(1'b1, 3'b100, 32'h0, 16'h0, 26'h000_0005, "R7");
      check("R7", "jump upper bits", pc_q, 32'h0400_0005);
      // R1: reset in mid-run while load is high
      @(negedge clk); rst = 1'b1; pc_load = 1'b1;
      @(posedge clk); #1;
      exp_pc = START;
      check("R1", "pc_q mid-run reset", pc_q, START);
      @(negedge clk); rst = 1'b0; pc_load = 1'b0;
      // R2: a long hold with changing selects
      step(1'b0, 3'b000, 32'hAAAA_AAAA, 16'h1234, 26'h155_5555, "R2");
      step(1'b0, 3'b111, 32'h0, 16'h8000, 26'h0, "R2");

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule